// File: doc/BRIEF.md
# Unrolled SHA-256 Compression Pipeline

This block computes the SHA-256 compression function. It is built as a fully unrolled chain of sixty-four round stages, and each stage holds one register slice. Every cycle it can accept a new job. A job is the 256-bit chaining value together with the sixty-four already-expanded schedule words. Once the chain has filled, it returns one finished 256-bit digest per cycle. Padding, schedule expansion and any comparison of the digest against a target are done by the logic around the block.

Each stage applies one round. The round constant is a per-stage parameter, and the rotations are fixed wiring. The round's additions are fused into carry-save trees, and each tree ends in a single ripple adder. The sum of schedule word and round constant is formed one stage ahead and registered, so it reaches the next round already combined. A valid bit travels beside the data. Slices whose valid bit is low keep their contents. The registered digest therefore only changes when a result comes out.

Top module: `shaCompressPipe`

## Requirements
- R1: While reset is high, and afterwards until the first result, outValid is 0 and outDigest is all zeros.
- R2: For each accepted job, outDigest equals the SHA-256 compression with feed-forward. Word j of inState sits at bits [255-32j:224-32j], so a is in the top word and h in the bottom word. Schedule word i of inWords sits at bits [32i+31:32i]. Digest word j is inState word j plus final working variable j, modulo 2^32, packed the same way.
- R3: A job sampled with inValid high at a rising edge delivers its result with outValid high after the 66th rising edge, counting the capture edge as the first.
- R4: A new job is accepted on every cycle. Back-to-back jobs give back-to-back results in the order they were accepted.
- R5: The pattern of outValid is the pattern of inValid delayed by the latency of R3. No result ever appears without a job.
- R6: While outValid is 0, outDigest keeps its previous value.
- R7: Values on inState and inWords during cycles with inValid low have no effect on any result.
- R8: All additions wrap modulo 2^32, including with every operand at 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A job is presented this cycle |
| inState | input | 256 | Chaining value, a in the top word |
| inWords | input | 2048 | Sixty-four expanded schedule words, word 0 in the low bits |
| outValid | output | 1 | outDigest carries a new result |
| outDigest | output | 256 | Compression result, first word in the top bits |

## Verification
The function is driven with the two standard single-block messages, "abc" and the empty string, whose digests are known constants. These cases separate a wrong constant, rotation or operand placement from a correct round. Long runs of pseudo-random jobs issued every cycle show whether jobs leak into each other or get reordered across slices. Sparse valid patterns with garbage on the data pins during the gaps show whether bubbles disturb neighbouring jobs or the held output. Saturated all-ones operands and all-zero operands push the carry-save trees and the final adders through full-width carries.

// File: rtl/shaPipePkg.sv
package shaPipePkg;
  localparam int WORD_W      = 32;
  localparam int STATE_WORDS = 8;
  localparam int STATE_W     = STATE_WORDS * WORD_W;
  localparam int NUM_ROUNDS  = 64;
  localparam int SCHED_W     = NUM_ROUNDS * WORD_W;
  localparam int CARRY_WORDS = NUM_ROUNDS - 1;
  localparam int CARRY_W     = CARRY_WORDS * WORD_W;
  localparam int PIPE_LAT    = NUM_ROUNDS + 2;

  typedef logic [WORD_W-1:0] word_t;

  // Redundant (carry-save) form of a sum.
  typedef struct packed {
    word_t sum;
    word_t carry;
  } redund_t;

  // Load strobes from control to datapath.
  typedef struct packed {
    logic                  entryLoad;
    logic [NUM_ROUNDS-1:0] roundLoad;
    logic                  outLoad;
  } pipeStrobe_t;

  // Round constants, round 0 in the top word.
  localparam logic [SCHED_W-1:0] ROUND_K = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic word_t roundConst(input int idx);
    if (idx < 0 || idx >= NUM_ROUNDS) return '0;
    return ROUND_K[SCHED_W-1-WORD_W*idx -: WORD_W];
  endfunction

  // Fixed rotate: pure wiring once n is constant.
  function automatic word_t rotR(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSig0(input word_t x);
    return rotR(x, 2) ^ rotR(x, 13) ^ rotR(x, 22);
  endfunction

  function automatic word_t bigSig1(input word_t x);
    return rotR(x, 6) ^ rotR(x, 11) ^ rotR(x, 25);
  endfunction

  function automatic word_t choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majority(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  // One full-adder row: three operands in, sum and shifted carry out.
  function automatic redund_t csa3(input word_t x, input word_t y, input word_t z);
    redund_t r;
    r.sum   = x ^ y ^ z;
    r.carry = ((x & y) | (x & z) | (y & z)) << 1;
    return r;
  endfunction

  // Two rows: four operands reduced to two.
  function automatic redund_t csa4(input word_t w, input word_t x, input word_t y, input word_t z);
    redund_t r;
    r = csa3(w, x, y);
    return csa3(r.sum, r.carry, z);
  endfunction
endpackage

// File: rtl/shaRoundStage.sv
module shaRoundStage
  import shaPipePkg::*;
#(
  parameter int STAGE = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [STATE_W-1:0] stateIn,
  input  logic [STATE_W-1:0] hIn,
  input  word_t              wkIn,
  input  logic [CARRY_W-1:0] wordsIn,
  output logic [STATE_W-1:0] stateOut,
  output logic [STATE_W-1:0] hOut,
  output word_t              wkOut,
  output logic [CARRY_W-1:0] wordsOut
);
  // Constant of the following round, folded into its schedule word here.
  localparam word_t NEXT_K = (STAGE < NUM_ROUNDS - 1) ? roundConst(STAGE + 1) : '0;

  word_t va, vb, vc, vd, ve, vf, vg, vh;
  assign {va, vb, vc, vd, ve, vf, vg, vh} = stateIn;

  redund_t t1Red, aRed, eRed;
  word_t   newA, newE;

  always_comb begin
    t1Red = csa4(vh, bigSig1(ve), choose(ve, vf, vg), wkIn);
    eRed  = csa3(t1Red.sum, t1Red.carry, vd);
    aRed  = csa4(t1Red.sum, t1Red.carry, bigSig0(va), majority(va, vb, vc));
    newE  = eRed.sum + eRed.carry;
    newA  = aRed.sum + aRed.carry;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      stateOut <= {newA, va, vb, vc, newE, ve, vf, vg};
      hOut     <= hIn;
      wkOut    <= wordsIn[WORD_W-1:0] + NEXT_K;
      wordsOut <= {{WORD_W{1'b0}}, wordsIn[CARRY_W-1:WORD_W]};
    end
  end

  // Chained two-input sums, used only to cross-check the fused trees.
  word_t plainT1, plainA, plainE;
  always_comb begin
    plainT1 = vh + bigSig1(ve);
    plainT1 = plainT1 + choose(ve, vf, vg);
    plainT1 = plainT1 + wkIn;
    plainA  = plainT1 + (bigSig0(va) + majority(va, vb, vc));
    plainE  = vd + plainT1;
  end

  // R2, R8: fused carry-save result matches chained modular adds
  a_r2_fused_new_a: assert property (@(posedge clk) disable iff (rst)
    load |-> (newA == plainA));
  a_r8_fused_new_e: assert property (@(posedge clk) disable iff (rst)
    load |-> (newE == plainE));
endmodule

// File: rtl/shaPipeDatapath.sv
module shaPipeDatapath
  import shaPipePkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pipeStrobe_t        strobe,
  input  logic [STATE_W-1:0] inState,
  input  logic [SCHED_W-1:0] inWords,
  output logic [STATE_W-1:0] digest
);
  // Entry slice: captures the job and pre-adds word 0 with constant 0.
  logic [STATE_W-1:0] entryState;
  word_t              entryWk;
  logic [CARRY_W-1:0] entryWords;

  always_ff @(posedge clk) begin
    if (strobe.entryLoad) begin
      entryState <= inState;
      entryWk    <= inWords[WORD_W-1:0] + roundConst(0);
      entryWords <= inWords[SCHED_W-1:WORD_W];
    end
  end

  logic [STATE_W-1:0] stateChain [NUM_ROUNDS];
  logic [STATE_W-1:0] hChain     [NUM_ROUNDS];
  word_t              wkChain    [NUM_ROUNDS];
  logic [CARRY_W-1:0] wordsChain [NUM_ROUNDS];

  for (genvar s = 0; s < NUM_ROUNDS; s++) begin : g_round
    logic [STATE_W-1:0] stIn;
    logic [STATE_W-1:0] chainIn;
    word_t              wkIn;
    logic [CARRY_W-1:0] wIn;
    if (s == 0) begin : g_first
      assign stIn    = entryState;
      assign chainIn = entryState;
      assign wkIn    = entryWk;
      assign wIn     = entryWords;
    end else begin : g_next
      assign stIn    = stateChain[s-1];
      assign chainIn = hChain[s-1];
      assign wkIn    = wkChain[s-1];
      assign wIn     = wordsChain[s-1];
    end
    shaRoundStage #(.STAGE(s)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .load     (strobe.roundLoad[s]),
      .stateIn  (stIn),
      .hIn      (chainIn),
      .wkIn     (wkIn),
      .wordsIn  (wIn),
      .stateOut (stateChain[s]),
      .hOut     (hChain[s]),
      .wkOut    (wkChain[s]),
      .wordsOut (wordsChain[s])
    );
  end

  // The last slice's look-ahead outputs feed nothing.
  logic unusedTail;
  assign unusedTail = ^{wkChain[NUM_ROUNDS-1], wordsChain[NUM_ROUNDS-1]};

  // Feed-forward: chaining value plus final working variables, word by word.
  logic [STATE_W-1:0] ffSum;
  always_comb begin
    for (int j = 0; j < STATE_WORDS; j++) begin
      ffSum[j*WORD_W +: WORD_W] = hChain[NUM_ROUNDS-1][j*WORD_W +: WORD_W]
                                + stateChain[NUM_ROUNDS-1][j*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 digest <= '0;
    else if (strobe.outLoad) digest <= ffSum;
  end
endmodule

// File: rtl/shaPipeControl.sv
module shaPipeControl
  import shaPipePkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output pipeStrobe_t strobe,
  output logic        outValid
);
  localparam int IF_W = $clog2(PIPE_LAT + 1) + 1;

  // validQ[0] marks the entry slice, validQ[s+1] round slice s.
  logic [PIPE_LAT-1:0] validQ;

  always_ff @(posedge clk) begin
    if (rst) validQ <= '0;
    else     validQ <= {validQ[PIPE_LAT-2:0], inValid};
  end

  assign strobe.entryLoad = inValid;
  assign strobe.roundLoad = validQ[NUM_ROUNDS-1:0];
  assign strobe.outLoad   = validQ[NUM_ROUNDS];
  assign outValid         = validQ[NUM_ROUNDS+1];

  // Jobs accepted but not yet returned.
  logic [IF_W-1:0] inFlight;
  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else     inFlight <= inFlight + IF_W'(inValid) - IF_W'(outValid);
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!outValid && strobe.roundLoad == '0 && !strobe.outLoad));
  a_r4_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    inFlight <= IF_W'(PIPE_LAT));
  a_r5_no_orphan_result: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inFlight != '0));
endmodule

// File: rtl/shaCompressPipe.sv
module shaCompressPipe
  import shaPipePkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [STATE_W-1:0] inState,
  input  logic [SCHED_W-1:0] inWords,
  output logic               outValid,
  output logic [STATE_W-1:0] outDigest
);
  pipeStrobe_t pipeStrobe;

  shaPipeControl u_control (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (pipeStrobe),
    .outValid (outValid)
  );

  shaPipeDatapath u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (pipeStrobe),
    .inState (inState),
    .inWords (inWords),
    .digest  (outDigest)
  );

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outDigest));
endmodule

// File: tb/shaCompressPipe_bench.sv
`timescale 1ns/1ps
module shaCompressPipe_bench;
  localparam int LAT = 66;
  localparam logic [255:0] IV = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [31:0] KT [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          inValid;
  logic [255:0]  inState;
  logic [2047:0] inWords;
  logic          outValid;
  logic [255:0]  outDigest;

  always #10 clk = ~clk;

  shaCompressPipe u_shaCompressPipe (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inState   (inState),
    .inWords   (inWords),
    .outValid  (outValid),
    .outDigest (outDigest)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int received = 0;
  bit monOn = 1'b0;
  logic [255:0] lastDigest;
  logic [255:0] expQ[$];
  int dueQ[$];
  logic [31:0] rngState = 32'h1badf00d;

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- reference model ----------------
  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [2047:0] expandBlock(input logic [511:0] blk);
    logic [31:0] w [64];
    logic [2047:0] r;
    for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 64; i++)
      w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
           + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
    for (int i = 0; i < 64; i++) r[32*i +: 32] = w[i];
    return r;
  endfunction

  function automatic logic [255:0] refCompress(input logic [255:0] st, input logic [2047:0] w);
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    {a, b, c, d, e, f, g, h} = st;
    for (int i = 0; i < 64; i++) begin
      t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KT[i] + w[32*i +: 32];
      t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
    end
    return {a + st[255:224], b + st[223:192], c + st[191:160], d + st[159:128],
            e + st[127:96],  f + st[95:64],   g + st[63:32],   h + st[31:0]};
  endfunction

  function automatic logic [31:0] nextRand();
    rngState = rngState ^ (rngState << 13);
    rngState = rngState ^ (rngState >> 17);
    rngState = rngState ^ (rngState << 5);
    return rngState;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic checkVal(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Output monitor: digest and arrival cycle for each result, hold in gaps.
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        received++;
        if (expQ.size() == 0) begin
          checkVal(1'b0, "R5 result without a job", outDigest, 256'h0);
        end else begin
          logic [255:0] e;
          int d;
          e = expQ.pop_front();
          d = dueQ.pop_front();
          checkVal(outDigest == e, "R2 digest", outDigest, e);
          checkVal(cyc == d, "R3 latency cycle", cyc, d);
        end
      end else begin
        checkVal(outDigest == lastDigest, "R6 digest hold", outDigest, lastDigest);
        if (dueQ.size() != 0 && dueQ[0] == cyc)
          checkVal(1'b0, "R5 missing result", cyc, dueQ[0]);
      end
      lastDigest = outDigest;
    end
  end

  task automatic sendItem(input logic [255:0] st, input logic [2047:0] w, input logic [255:0] exp);
    @(negedge clk);
    inValid = 1'b1;
    inState = st;
    inWords = w;
    expQ.push_back(exp);
    dueQ.push_back(cyc + LAT);
  endtask

  task automatic sendRandom();
    logic [255:0] st;
    logic [2047:0] w;
    for (int i = 0; i < 8; i++) st[32*i +: 32] = nextRand();
    for (int i = 0; i < 64; i++) w[32*i +: 32] = nextRand();
    sendItem(st, w, refCompress(st, w));
  endtask

  task automatic idleCycle(input bit garbage);
    @(negedge clk);
    inValid = 1'b0;
    if (garbage) begin
      for (int i = 0; i < 8; i++) inState[32*i +: 32] = nextRand();
      for (int i = 0; i < 64; i++) inWords[32*i +: 32] = nextRand();
    end
  endtask

  task automatic drain(input string tag, input int startRecv, input int expectCount);
    idleCycle(1'b1);
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    checkVal(received - startRecv == expectCount, tag, received - startRecv, expectCount);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1;
    inValid = 1'b1;
    inState = '1;
    inWords = '1;
    repeat (4) @(negedge clk);
    checkVal(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    checkVal(outDigest == '0, "R1 digest in reset", outDigest, 0);
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    lastDigest = outDigest;
    monOn = 1'b1;
    repeat (5) @(negedge clk);
    checkVal(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    checkVal(outDigest == '0, "R1 digest after reset", outDigest, 0);
  endtask

  task automatic t_standard();
    int start = received;
    logic [2047:0] wAbc, wEmpty;
    wAbc   = expandBlock({32'h61626380, 448'h0, 32'h00000018});
    wEmpty = expandBlock({32'h80000000, 480'h0});
    sendItem(IV, wAbc, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
    sendItem(IV, wEmpty, 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855);
    drain("R2 standard vectors returned", start, 2);
  endtask

  task automatic t_burst();
    int start = received;
    for (int i = 0; i < 80; i++) sendRandom();
    drain("R4 back-to-back burst count", start, 80);
  endtask

  task automatic t_bubbles();
    int start = received;
    int ones = 0;
    logic [23:0] pattern = 24'b1001_0110_1100_0101_0011_1001;
    for (int i = 0; i < 24; i++) begin
      if (pattern[i]) begin
        sendRandom();
        ones++;
      end else begin
        idleCycle(1'b1);
      end
    end
    drain("R7 bubble pattern result count (R5)", start, ones);
  endtask

  task automatic t_wrap();
    int start = received;
    logic [255:0] ones256 = '1;
    logic [2047:0] onesW = '1;
    sendItem(ones256, onesW, refCompress(ones256, onesW));
    sendItem('0, '0, refCompress('0, '0));
    sendItem(ones256, '0, refCompress(ones256, '0));
    drain("R8 saturated operands count", start, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_standard();
    t_burst();
    t_bubbles();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule